// File: doc/BRIEF.md
# Latched-Reload Watchdog Timer

A supervision counter that guards against stalled software. After reset it stays inert. The first write of a nonzero value through its write port does two things: it stores that value as the timeout and it starts a count of input clock cycles down toward zero. Once the timer is running, any further write reloads the stored timeout. The data carried by that later write is thrown away, so software only has to touch the port regularly to keep the timer from expiring.

If software stops writing, the count reaches zero. The block then emits a one-cycle reset request, which feeds the chip's reset network, and sets a sticky cause flag inside a status word. After a restart, software reads that flag to tell a watchdog reset from an external one. The flag survives the system reset that the watchdog itself causes, and only power-on reset clears it. A write of zero also clears it, and a zero write never starts the timer.

Top module: `wdt_latched_top`

## Requirements
- R1: After power-on reset the timer is disarmed, the reset request output is low, and every bit of the status word reads zero.
- R2: A write of a nonzero value N while disarmed stores N and arms the timer. The reset request rises N clock edges after the write edge, so N=1 gives a request on the very next edge.
- R3: While armed, every write reloads the value stored by the first write, whatever data it carries. Expiry then falls N edges after the latest write.
- R4: The reset request lasts exactly one cycle. The timer is then disarmed with its stored value cleared, so the next nonzero write stores a fresh timeout, and no further request occurs without a new write.
- R5: At expiry the cause flag is set, in the same cycle as the request. It is visible as bit 1 of the status word, and all other status bits read zero.
- R6: A write of zero clears the cause flag. While disarmed, a zero write neither arms the timer nor causes any request.
- R7: The cause flag is unaffected by the system reset input and is cleared by power-on reset.
- R8: System reset disarms the timer and clears the stored timeout, so the next nonzero write becomes the new timeout.
- R9: A write landing on the edge where the count would expire wins: the request is suppressed and the count restarts from the stored value.
- R10: A zero write while armed reloads the stored timeout and also clears the cause flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock counted by the timer |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, clears all but the cause flag |
| wr_en | input | 1 | Write strobe for the timeout port |
| wr_data | input | CNT_W (16) | Write data; only used on the arming write, or tested for zero |
| wdog_rst_o | output | 1 | One-cycle reset request at expiry |
| sys_status_o | output | STAT_W (8) | Status word; bit 1 is the watchdog cause flag |

## Verification
The hardest case to produce is a kick arriving on exactly the edge where the count would expire. The bench reaches it by counting edges from the arming write and placing a second write N edges later, then checking that no request appears and that a new expiry falls N edges after that write. Ignored data is shown by kicking with values that differ from the stored timeout and timing the resulting expiry against the stored value. The cause flag's survival is shown by pulsing system reset after an expiry and reading the status word.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      WDT_IDLE  = 1'b0,
      WDT_ARMED = 1'b1
   } wdt_state_e;

   localparam int WDT_CAUSE_BIT_DEF = 1;
endpackage

// File: rtl/wdt_arm_latch.sv
module wdt_arm_latch
   import wdt_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             srst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             expire_now,
   output logic             armed,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);
   wdt_state_e       state_q;
   logic [CNT_W-1:0] tmo_q;
   logic             data_nz;

   assign data_nz  = |wr_data;
   assign armed    = (state_q == WDT_ARMED);
   // a write reloads when armed; a nonzero write arms when idle
   assign load     = wr_en && (armed || data_nz);
   assign load_val = armed ? tmo_q : wr_data;

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
         state_q <= WDT_IDLE;
         tmo_q   <= '0;
      end else if (load && !armed) begin
         state_q <= WDT_ARMED;
         tmo_q   <= wr_data;
      end else if (expire_now) begin
         state_q <= WDT_IDLE;
         tmo_q   <= '0;
      end
   end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             srst_n,
   input  logic             armed,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire_now,
   output logic             pulse_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   // expiry happens on the edge that would move the count from one to zero
   assign expire_now = armed && !load && (cnt_q == ONE);

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
         cnt_q   <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= expire_now;
         if (load)
            cnt_q <= load_val;
         else if (armed && cnt_q != '0)
            cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/wdt_cause_flag.sv
module wdt_cause_flag #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             por_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             expire_now,
   output logic             cause
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cause <= 1'b0;
      else if (expire_now)
         cause <= 1'b1;
      else if (wr_en && wr_data == '0)
         cause <= 1'b0;
   end
endmodule

// File: rtl/wdt_latched_top.sv
module wdt_latched_top #(
   parameter int CNT_W     = 16,
   parameter int STAT_W    = 8,
   parameter int CAUSE_BIT = wdt_pkg::WDT_CAUSE_BIT_DEF
)(
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_data,
   output logic              wdog_rst_o,
   output logic [STAT_W-1:0] sys_status_o
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("CNT_W out of range");
      end
      if (CAUSE_BIT < 0 || CAUSE_BIT >= STAT_W) begin : g_bad_bit
         $error("CAUSE_BIT outside status word");
      end
   endgenerate

   logic             srst_n;
   logic             armed;
   logic             load;
   logic             expire_now;
   logic             cause;
   logic [CNT_W-1:0] load_val;

   assign srst_n = rst_n & por_n;

   wdt_arm_latch #(.CNT_W(CNT_W)) u_arm (
      .clk(clk), .srst_n(srst_n), .wr_en(wr_en), .wr_data(wr_data),
      .expire_now(expire_now), .armed(armed), .load(load), .load_val(load_val)
   );

   wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .srst_n(srst_n), .armed(armed), .load(load),
      .load_val(load_val), .expire_now(expire_now), .pulse_o(wdog_rst_o)
   );

   wdt_cause_flag #(.CNT_W(CNT_W)) u_cause (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
      .expire_now(expire_now), .cause(cause)
   );

   generate
      for (genvar i = 0; i < STAT_W; i++) begin : g_stat
         if (i == CAUSE_BIT) begin : g_c
            assign sys_status_o[i] = cause;
         end else begin : g_z
            assign sys_status_o[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/wdt_latched_chk.sv
module wdt_latched_chk #(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic             wdog_rst_o,
   input logic             cause,
   input logic             armed
);
   // R4: request lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      wdog_rst_o |=> !wdog_rst_o);
   // R4: disarmed while the request is out
   a_r4_disarm_on_pulse: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      wdog_rst_o |-> !armed);
   // R5: cause only rises together with a request
   a_r5_cause_with_pulse: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      $rose(cause) |-> wdog_rst_o);
   // R6: zero write clears cause
   a_r6_zero_clears: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (wr_en && wr_data == '0) |=> !cause);
   // R6: zero write while idle does not arm
   a_r6_zero_no_arm: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (!armed && wr_en && wr_data == '0) |=> !armed);
   // R9: a write suppresses the request on the next edge
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (armed && wr_en) |=> !wdog_rst_o);
endmodule

bind wdt_latched_top wdt_latched_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .wdog_rst_o(wdog_rst_o), .cause(cause), .armed(armed)
);

// File: tb/sim_wdt_latched_top.sv
`timescale 1ns/1ps
module sim_wdt_latched_top;
   localparam int CNT_W = 16;
   localparam int STAT_W = 8;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic              wdog_rst_o;
   logic [STAT_W-1:0] sys_status_o;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int pulses = 0;
   bit done = 0;

   // reference model state
   bit          m_armed = 0;
   int          m_tmo = 0;
   bit          m_cause = 0;
   int          expq[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_latched_top #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wdog_rst_o(wdog_rst_o), .sys_status_o(sys_status_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: write and push the expected expiry edge
   task automatic wr(input logic [CNT_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (d == 0) m_cause = 0;
      if (m_armed || d != 0) begin
         if (!m_armed) m_tmo = int'(d);
         m_armed = 1;
         expq.delete();
         expq.push_back(cyc + m_tmo);
      end
   endtask

   task automatic sys_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_armed = 0;
      expq.delete();
   endtask

   task automatic por();
      @(negedge clk);
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      rst_n = 1'b1;
      m_armed = 0;
      m_cause = 0;
      expq.delete();
   endtask

   // monitor: compare the request and status against the queue
   always @(negedge clk) begin
      if (por_n && rst_n) begin
         if (wdog_rst_o) pulses++;
         if (expq.size() > 0 && expq[0] == cyc) begin
            void'(expq.pop_front());
            m_armed = 0;
            m_cause = 1;
            chk(wdog_rst_o == 1'b1, "R2/R3 expiry request", wdog_rst_o, 1);
            chk(sys_status_o == 8'h02, "R5 cause at bit 1", sys_status_o, 8'h02);
         end else if (wdog_rst_o) begin
            chk(1'b0, "R4/R6/R9 unexpected request", 1, 0);
         end
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(wdog_rst_o == 0, "R1 request low", wdog_rst_o, 0);
      chk(sys_status_o == 0, "R1 status zero", sys_status_o, 0);
      repeat (20) @(posedge clk);
      chk(pulses == 0, "R1 no request while idle", pulses, 0);

      // R6: zero write while idle
      wr(16'h0000);
      repeat (40) @(posedge clk);
      chk(pulses == 0, "R6 zero write does not arm", pulses, 0);

      // R2, R5: arm with 10
      wr(16'd10);
      repeat (15) @(posedge clk);
      @(negedge clk);
      chk(pulses == 1, "R2 one expiry", pulses, 1);
      // R4: no repeat
      repeat (30) @(posedge clk);
      chk(pulses == 1, "R4 no further request", pulses, 1);
      // R7: survives system reset
      sys_reset();
      @(negedge clk);
      chk(sys_status_o[1] == 1'b1, "R7 cause survives rst_n", sys_status_o[1], 1);
      // R6: zero clears
      wr(16'h0000);
      @(negedge clk);
      chk(sys_status_o[1] == 1'b0, "R6 zero write clears cause", sys_status_o[1], 0);
      repeat (40) @(posedge clk);
      chk(pulses == 1, "R6 still disarmed", pulses, 1);

      // R3: kicks with other data keep stored 20
      wr(16'd20);
      for (int k = 0; k < 5; k++) begin
         repeat (8) @(posedge clk);
         wr(16'd3);
      end
      repeat (12) @(posedge clk);
      chk(pulses == 1, "R3 kicks ignored data value 3", pulses, 1);
      repeat (15) @(posedge clk);
      chk(pulses == 2, "R3 expiry from stored value", pulses, 2);

      // R4: fresh timeout after expiry
      wr(16'd5);
      repeat (8) @(posedge clk);
      chk(pulses == 3, "R4 new timeout stored", pulses, 3);

      // R9: write on the expiry edge
      wr(16'd6);
      repeat (5) @(posedge clk);
      p0 = pulses;
      wr(16'd9);
      @(negedge clk);
      chk(pulses == p0, "R9 colliding write suppresses request", pulses, p0);
      repeat (12) @(posedge clk);
      chk(pulses == p0 + 1, "R9 reload then expiry", pulses, p0 + 1);

      // R10: zero kick while armed with cause set
      wr(16'd30);
      repeat (5) @(posedge clk);
      wr(16'h0000);
      @(negedge clk);
      chk(sys_status_o[1] == 1'b0, "R10 zero kick clears cause", sys_status_o[1], 0);
      repeat (35) @(posedge clk);
      chk(pulses == p0 + 2, "R10 zero kick reloads", pulses, p0 + 2);

      // R8: system reset clears stored timeout
      wr(16'd40);
      repeat (10) @(posedge clk);
      sys_reset();
      wr(16'd7);
      repeat (50) @(posedge clk);
      chk(pulses == p0 + 3, "R8 new value after rst_n", pulses, p0 + 3);

      // R7: power-on clears cause
      por();
      @(negedge clk);
      chk(sys_status_o == 0, "R7 por clears cause", sys_status_o, 0);

      // R2: boundary N=1 and N=max
      wr(16'd1);
      repeat (3) @(posedge clk);
      chk(pulses == p0 + 4, "R2 N=1 expiry", pulses, p0 + 4);
      wr(16'hFFFF);
      repeat (65540) @(posedge clk);
      chk(pulses == p0 + 5, "R2 N=max expiry", pulses, p0 + 5);
      chk(expq.size() == 0, "R2 all expiries seen", expq.size(), 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule